// File: doc/BRIEF.md
# Programmable Line Pulse Timing Generator

This block generates the horizontal timing of a video line. A line counter advances by one on every display clock and returns to zero when a line-start strobe arrives. Several edge pulses, such as horizontal drive, blanking and memory read or write enables, are built from the counter. Each edge pulse has a programmed rise value and a programmed fall value. Four strobe outputs each produce a single one-clock pulse at one programmed position.

A two-bit frequency-mode input selects how programmed values turn into clock positions. The 27 MHz and 32 MHz acquisition modes use a fine grid. The 36 MHz mode uses a grid twice as coarse. Each mode has its own legal range for programmed values. A setting outside that range, or an edge pulse whose rise and fall values are equal, holds that pulse low and raises a per-pulse error flag. The programmed values come from registers outside the block, and vertical timing is handled elsewhere.

Top module: `line_pulse_gen`

## Requirements
- R1: Reset clears the line count and drives every output low. When `line_start_i` is sampled high on a clock edge, the line count c is 0 after that edge. Otherwise c increments by one on each edge. Every output is registered from the c value and the inputs present at an edge, so it shows them one cycle later.
- R2: With mode 0 (27 MHz) or mode 1 (32 MHz), edge pulse i is high for counts c with 2·rise+2 ≤ c < 2·fall+2, when rise < fall. The rise value sits in bits [9i+8:9i] of `edge_rise_i` and the fall value in the same bits of `edge_fall_i`.
- R3: With mode 2 (36 MHz), edge pulse positions are 4·rise+4 and 4·fall+4.
- R4: Strobe j is high for exactly one count, c = 4·N+2 in modes 0 and 1 and c = 8·N+4 in modes 2 and 3. N sits in bits [9j+8:9j] of `strobe_pos_i`.
- R5: When the fall position is below the rise position, the pulse wraps. It is high for c ≥ rise position or c < fall position.
- R6: Legal edge values are below 431 (mode 0), below 511 (mode 1) and below 287 (modes 2 and 3). If the rise or fall value is out of range, the pulse is held low and its `edge_err_o` bit is high. Otherwise that bit is low.
- R7: If the rise value equals the fall value, the pulse is held low and its `edge_err_o` bit is high.
- R8: Legal strobe values are below 215, 255 and 145 for modes 0, 1 and 2/3. An out-of-range strobe stays low and its `strobe_err_o` bit is high.
- R9: Mode 3 behaves exactly like mode 2.
- R10: Without a line start, the count stops at 2047 and holds there. Pulses keep following c = 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Line-start strobe, restarts the count |
| mode_i | input | 2 | Frequency mode: 0=27, 1=32, 2/3=36 MHz |
| edge_rise_i | input | 36 | Four 9-bit rise values |
| edge_fall_i | input | 36 | Four 9-bit fall values |
| strobe_pos_i | input | 36 | Four 9-bit strobe positions |
| edge_o | output | 4 | Edge pulse outputs |
| edge_err_o | output | 4 | Per-edge-pulse setting error |
| strobe_o | output | 4 | One-clock strobe outputs |
| strobe_err_o | output | 4 | Per-strobe setting error |

## Verification
The bench sweeps every mode across the last legal value and the first illegal value. A wrong limit shows up as a pulse firing where the error flag should hold it low, or as a valid pulse being suppressed.

Wrapped pulses and equal rise/fall settings are driven on purpose. A design that compares only rise < c < fall would give a pulse that never appears or one that lasts the whole line.

A long line without any line start checks saturation. A counter that rolls over would restart strobes and reopen windows a second time.

Mode 3 and the off-by-one latency of the registered outputs are compared cycle by cycle against the model. A one-cycle shift or a wrong scale factor shows up as a mismatch on the first edge.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  // Modes 2 and 3 both select the coarse 36 MHz grid.
  function automatic logic coarse_grid(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic int edge_limit(input logic [1:0] mode);
    case (mode)
      2'd0:    return 431;
      2'd1:    return 511;
      default: return 287;
    endcase
  endfunction

  function automatic int strobe_limit(input logic [1:0] mode);
    case (mode)
      2'd0:    return 215;
      2'd1:    return 255;
      default: return 145;
    endcase
  endfunction

endpackage

// File: rtl/lpg_line_counter.sv
module lpg_line_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || line_start_i)
      cnt_q <= '0;
    else if (cnt_q != CNT_MAX)
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lpg_edge_unit.sv
module lpg_edge_unit
  import lpg_pkg::*;
#(
  parameter int VAL_W = 9,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       mode_i,
  input  logic [VAL_W-1:0] rise_i,
  input  logic [VAL_W-1:0] fall_i,
  output logic             pulse_o,
  output logic             err_o
);
  int   rise_pos, fall_pos, cnt_v, lim;
  logic bad, level;

  always_comb begin
    lim   = edge_limit(mode_i);
    cnt_v = int'(cnt_i);
    if (coarse_grid(mode_i)) begin
      rise_pos = 4 * int'(rise_i) + 4;
      fall_pos = 4 * int'(fall_i) + 4;
    end else begin
      rise_pos = 2 * int'(rise_i) + 2;
      fall_pos = 2 * int'(fall_i) + 2;
    end
    bad = (int'(rise_i) >= lim) || (int'(fall_i) >= lim) || (rise_i == fall_i);
    if (rise_pos < fall_pos)
      level = (cnt_v >= rise_pos) && (cnt_v < fall_pos);
    else
      level = (cnt_v >= rise_pos) || (cnt_v < fall_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      pulse_o <= level && !bad;
      err_o   <= bad;
    end
  end
endmodule

// File: rtl/lpg_strobe_unit.sv
module lpg_strobe_unit
  import lpg_pkg::*;
#(
  parameter int VAL_W = 9,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       mode_i,
  input  logic [VAL_W-1:0] pos_i,
  output logic             pulse_o,
  output logic             err_o
);
  int   at;
  logic bad;

  always_comb begin
    at  = coarse_grid(mode_i) ? 8 * int'(pos_i) + 4 : 4 * int'(pos_i) + 2;
    bad = int'(pos_i) >= strobe_limit(mode_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      pulse_o <= (int'(cnt_i) == at) && !bad;
      err_o   <= bad;
    end
  end
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen #(
  parameter int NUM_EDGE   = 4,
  parameter int NUM_STROBE = 4,
  parameter int VAL_W      = 9,
  parameter int CNT_W      = 11
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        line_start_i,
  input  logic [1:0]                  mode_i,
  input  logic [NUM_EDGE*VAL_W-1:0]   edge_rise_i,
  input  logic [NUM_EDGE*VAL_W-1:0]   edge_fall_i,
  input  logic [NUM_STROBE*VAL_W-1:0] strobe_pos_i,
  output logic [NUM_EDGE-1:0]         edge_o,
  output logic [NUM_EDGE-1:0]         edge_err_o,
  output logic [NUM_STROBE-1:0]       strobe_o,
  output logic [NUM_STROBE-1:0]       strobe_err_o
);
  logic [CNT_W-1:0] cnt_q;

  lpg_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .line_start_i(line_start_i), .cnt_o(cnt_q)
  );

  for (genvar i = 0; i < NUM_EDGE; i++) begin : g_edge
    lpg_edge_unit #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_edge (
      .clk(clk), .rst(rst), .cnt_i(cnt_q), .mode_i(mode_i),
      .rise_i(edge_rise_i[i*VAL_W +: VAL_W]),
      .fall_i(edge_fall_i[i*VAL_W +: VAL_W]),
      .pulse_o(edge_o[i]), .err_o(edge_err_o[i])
    );
  end

  for (genvar j = 0; j < NUM_STROBE; j++) begin : g_strobe
    lpg_strobe_unit #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_strb (
      .clk(clk), .rst(rst), .cnt_i(cnt_q), .mode_i(mode_i),
      .pos_i(strobe_pos_i[j*VAL_W +: VAL_W]),
      .pulse_o(strobe_o[j]), .err_o(strobe_err_o[j])
    );
  end
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int NUM_EDGE   = 4,
  parameter int NUM_STROBE = 4,
  parameter int VAL_W      = 9,
  parameter int CNT_W      = 11
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        line_start_i,
  input logic [NUM_EDGE*VAL_W-1:0]   edge_rise_i,
  input logic [NUM_EDGE*VAL_W-1:0]   edge_fall_i,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [NUM_EDGE-1:0]         edge_o,
  input logic [NUM_EDGE-1:0]         edge_err_o,
  input logic [NUM_STROBE-1:0]       strobe_o,
  input logic [NUM_STROBE-1:0]       strobe_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    line_start_i |=> cnt_q == '0);

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!line_start_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
    (!line_start_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  for (genvar i = 0; i < NUM_EDGE; i++) begin : g_e
    p_err_low_r6: assert property (@(posedge clk) disable iff (rst)
      edge_err_o[i] |-> !edge_o[i]);
    p_equal_err_r7: assert property (@(posedge clk) disable iff (rst)
      (edge_rise_i[i*VAL_W +: VAL_W] == edge_fall_i[i*VAL_W +: VAL_W]) |=> edge_err_o[i]);
  end

  for (genvar j = 0; j < NUM_STROBE; j++) begin : g_s
    p_one_wide_r4: assert property (@(posedge clk) disable iff (rst)
      strobe_o[j] |=> !strobe_o[j]);
    p_err_low_r8: assert property (@(posedge clk) disable iff (rst)
      strobe_err_o[j] |-> !strobe_o[j]);
  end
endmodule

bind line_pulse_gen lpg_checker #(
  .NUM_EDGE(NUM_EDGE), .NUM_STROBE(NUM_STROBE), .VAL_W(VAL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .line_start_i(line_start_i),
  .edge_rise_i(edge_rise_i), .edge_fall_i(edge_fall_i), .cnt_q(cnt_q),
  .edge_o(edge_o), .edge_err_o(edge_err_o),
  .strobe_o(strobe_o), .strobe_err_o(strobe_err_o)
);

// File: tb/line_pulse_gen_test.sv
module line_pulse_gen_test;
  localparam int NE = 4, NS = 4, VW = 9, CMAX = 2047;

  logic clk = 1'b0, rst = 1'b1, line_start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [NE*VW-1:0] rise_v = '0, fall_v = '0;
  logic [NS*VW-1:0] strb_v = '0;
  logic [NE-1:0] edge_o, edge_err;
  logic [NS-1:0] strobe_o, strobe_err;

  int tests = 0, fails = 0, cycles = 0;
  bit chk_en = 0, done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  line_pulse_gen uut (
    .clk(clk), .rst(rst), .line_start_i(line_start), .mode_i(mode),
    .edge_rise_i(rise_v), .edge_fall_i(fall_v), .strobe_pos_i(strb_v),
    .edge_o(edge_o), .edge_err_o(edge_err),
    .strobe_o(strobe_o), .strobe_err_o(strobe_err)
  );

  // Behavioural reference model
  int mcnt = 0;
  logic [NE-1:0] x_edge = '0, x_eerr = '0;
  logic [NS-1:0] x_strb = '0, x_serr = '0;

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; x_edge = '0; x_eerr = '0; x_strb = '0; x_serr = '0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        int r, f, lim, rp, fp;
        bit bad;
        r = int'(rise_v[i*VW +: VW]); f = int'(fall_v[i*VW +: VW]);
        lim = (mode == 0) ? 431 : (mode == 1) ? 511 : 287;
        rp = (mode >= 2) ? 4*r+4 : 2*r+2;
        fp = (mode >= 2) ? 4*f+4 : 2*f+2;
        bad = (r >= lim) || (f >= lim) || (r == f);
        x_eerr[i] = bad;
        x_edge[i] = !bad && ((rp < fp) ? (mcnt >= rp && mcnt < fp) : (mcnt >= rp || mcnt < fp));
      end
      for (int j = 0; j < NS; j++) begin
        int n, lim;
        n = int'(strb_v[j*VW +: VW]);
        lim = (mode == 0) ? 215 : (mode == 1) ? 255 : 145;
        x_serr[j] = n >= lim;
        x_strb[j] = (n < lim) && (mcnt == ((mode >= 2) ? 8*n+4 : 4*n+2));
      end
      if (line_start) mcnt = 0;
      else if (mcnt < CMAX) mcnt = mcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !rst && !done) begin
      tests++;
      if ({edge_o, edge_err, strobe_o, strobe_err} !== {x_edge, x_eerr, x_strb, x_serr}) begin
        fails++;
        $display("FAIL %s cycle %0d: edge=%b eerr=%b strb=%b serr=%b expected edge=%b eerr=%b strb=%b serr=%b",
                 cur_req, cycles, edge_o, edge_err, strobe_o, strobe_err,
                 x_edge, x_eerr, x_strb, x_serr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic set_edge(int i, int r, int f);
    rise_v[i*VW +: VW] = VW'(r);
    fall_v[i*VW +: VW] = VW'(f);
  endtask

  task automatic set_strb(int j, int n);
    strb_v[j*VW +: VW] = VW'(n);
  endtask

  task automatic lines(int len, int n);
    for (int k = 0; k < n; k++) begin
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      repeat (len - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible before any edge with reset low
    tests++;
    if ({edge_o, edge_err, strobe_o, strobe_err} !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 0", {edge_o, edge_err, strobe_o, strobe_err});
    end
    chk_en = 1;

    // R1/R2: 27 MHz mode, plain windows and latency
    cur_req = "R2";
    mode = 2'd0;
    set_edge(0, 5, 20); set_edge(1, 0, 1); set_edge(2, 100, 430); set_edge(3, 7, 8);
    set_strb(0, 0); set_strb(1, 3); set_strb(2, 10); set_strb(3, 214);
    lines(900, 2);

    // R4 and R8 with R6 limits in 27 MHz mode: first illegal values
    cur_req = "R8";
    set_strb(3, 215); set_edge(2, 100, 431);
    lines(300, 1);

    // R6: 32 MHz mode, top legal value 510 and first illegal 511
    cur_req = "R6";
    mode = 2'd1;
    set_edge(0, 3, 510); set_edge(1, 511, 2); set_edge(2, 430, 431);
    set_strb(0, 254); set_strb(1, 255); set_strb(3, 214);
    lines(1100, 1);

    // R3: 36 MHz mode positions, limits 287/145
    cur_req = "R3";
    mode = 2'd2;
    set_edge(0, 10, 286); set_edge(1, 0, 287); set_edge(2, 1, 2);
    set_strb(0, 0); set_strb(1, 143); set_strb(2, 144); set_strb(3, 145);
    lines(1200, 2);

    // R5: wrap-around windows in both grids
    cur_req = "R5";
    set_edge(0, 30, 5); set_edge(1, 200, 1);
    lines(1000, 2);
    mode = 2'd0;
    set_edge(2, 400, 3); set_edge(3, 9, 0);
    lines(900, 2);

    // R7: equal rise and fall values
    cur_req = "R7";
    set_edge(0, 12, 12); set_edge(1, 0, 0);
    lines(100, 1);

    // R9: mode 3 identical to mode 2
    cur_req = "R9";
    mode = 2'd3;
    set_edge(0, 10, 40); set_edge(1, 286, 4);
    set_strb(0, 5); set_strb(1, 144);
    lines(1200, 1);

    // R10: long line without restart, count saturates
    cur_req = "R10";
    mode = 2'd0;
    set_edge(0, 300, 20); set_edge(1, 2, 6); set_strb(0, 1);
    lines(2600, 1);
    lines(50, 1);

    chk_en = 0;
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule